// File: doc/BRIEF.md
# RTC Seconds Counter, Alarm and Interrupt Registers

This unit keeps wall-clock time as a 32-bit count of seconds and raises interrupts for two sources: every elapsed second and a match against a programmable 32-bit alarm value. A prescaler outside the block supplies a one-cycle `sec_tick` strobe once per second. Software reaches the unit through a flat 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data.

Setting the time is deferred. A write to the time-set word goes into a holding register and arms a two-state loader. The loader starts in `LD_IDLE`. On a time-set write it goes to `LD_ARMED` (transition *arm*). In `LD_ARMED` the next strobe copies the held value into the counter and returns to `LD_IDLE` (transition *load*). A time-set write that arrives together with that strobe keeps the loader in `LD_ARMED` (transition *re-arm*). Until the load happens, software reads the held value at its own readback word. The counter word still shows the old time.

Each interrupt source has a sticky status bit that software clears by writing 1. It also has a mask bit. A write-1 to the enable word clears the mask bit, and a write-1 to the disable word sets it. Each interrupt pin is high while its status bit is set and its source is unmasked. A small control word holds an oscillator-enable bit and a battery-switch-enable bit. A calibration word is kept for the prescaler.

Top module: `rtc_time_alarm`

## Requirements
- R1: After reset the current time, the held set value, the alarm, the calibration and the control words read 0. The status word reads 0, the mask word reads 2'b11 (both masked), and both interrupt pins are low.
- R2: A write to offset 0x00 does not change the current time at 0x10. Offset 0x04 returns the written value. On the next `sec_tick`, 0x10 takes the written value.
- R3: On a `sec_tick` with no pending load, the current time increments by one, wrapping from 0xFFFFFFFF to 0. Without a strobe it holds.
- R4: A time-set write in the same cycle as a `sec_tick` is not loaded by that strobe. That strobe applies an older pending value if there is one, or else increments, and the new value loads on the following strobe.
- R5: Status bit 0 (seconds event, word 0x20) is set in the cycle after each `sec_tick`.
- R6: Status bit 1 (alarm event) is set in the cycle after the current time equals the alarm word (0x18). It sets again on every cycle while they stay equal, even right after a clear.
- R7: A write to 0x20 clears each status bit written as 1 and leaves bits written as 0 unchanged. A set event in the same cycle wins over the clear.
- R8: Writing 1 to bit n of 0x28 unmasks source n, and writing 1 to bit n of 0x2C masks it. Zero bits have no effect. 0x24 reads the mask, with 1 meaning masked.
- R9: `irq_sec` is high exactly when status bit 0 is set and mask bit 0 is clear. `irq_alarm` follows the same rule with bit 1.
- R10: The control word at 0x40 stores bits 31 (battery-switch enable) and 24 (oscillator enable) on write. All its other bits read 0.
- R11: A write to 0x08 stores the low 21 bits, which read back at 0x0C. Writes to the read-only words 0x04, 0x0C and 0x10 change nothing.
- R12: The write-only words (0x00, 0x08, 0x28, 0x2C), the tick word 0x14 and every unused offset read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle seconds strobe from the prescaler |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench builds the unit with its default widths: a 32-bit data path, an 8-bit offset and a 21-bit calibration field. With these widths, loading 0xFFFFFFFF through the deferred set path drives the counter to its wrap edge within two strobes. The default widths also let the alarm be placed a few seconds ahead of the time, so the alarm match that keeps setting again during a clear and the collisions between a strobe and a time-set write both occur within a few dozen cycles.

// File: rtl/rtc_ta_pkg.sv
package rtc_ta_pkg;

    // Register byte offsets (software-visible layout)
    localparam logic [7:0] OFS_TSET      = 8'h00;
    localparam logic [7:0] OFS_TSET_RB   = 8'h04;
    localparam logic [7:0] OFS_CAL_WR    = 8'h08;
    localparam logic [7:0] OFS_CAL_RD    = 8'h0C;
    localparam logic [7:0] OFS_NOW       = 8'h10;
    localparam logic [7:0] OFS_TICK      = 8'h14;
    localparam logic [7:0] OFS_ALARM     = 8'h18;
    localparam logic [7:0] OFS_STAT      = 8'h20;
    localparam logic [7:0] OFS_MASK      = 8'h24;
    localparam logic [7:0] OFS_UNMASK    = 8'h28;
    localparam logic [7:0] OFS_DOMASK    = 8'h2C;
    localparam logic [7:0] OFS_CTRL      = 8'h40;

    // Interrupt sources: position in status, mask and pin vectors
    localparam int unsigned SRC_SEC  = 0;
    localparam int unsigned SRC_ALM  = 1;
    localparam int unsigned NUM_SRC  = 2;

    // Control word bits that hold state
    localparam int unsigned CTRL_BATT_BIT = 31;
    localparam int unsigned CTRL_OSC_BIT  = 24;

    // Deferred time-set loader
    typedef enum logic [0:0] {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } load_state_e;

endpackage

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_ta_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              set_wr,
    input  logic [DATA_W-1:0] set_data,
    output logic [DATA_W-1:0] cur_time,
    output logic [DATA_W-1:0] set_hold,
    output logic              load_pending
);

    load_state_e       state_q;
    load_state_e       state_d;
    logic              load_now;
    logic [DATA_W-1:0] time_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and load decision
    always_comb begin
        state_d  = state_q;
        load_now = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (set_wr) begin
                    state_d = LD_ARMED;
                end
            end
            LD_ARMED: begin
                load_now = sec_tick;
                if (sec_tick && !set_wr) begin
                    state_d = LD_IDLE;
                end
            end
            default: begin
                state_d = LD_IDLE;
            end
        endcase
    end

    always_comb begin
        time_d = cur_time;
        if (sec_tick) begin
            time_d = load_now ? set_hold : cur_time + DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_time <= '0;
            set_hold <= '0;
        end else begin
            cur_time <= time_d;
            if (set_wr) begin
                set_hold <= set_data;
            end
        end
    end

    assign load_pending = (state_q == LD_ARMED);

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            clr_wr,
    input  logic            en_wr,
    input  logic            dis_wr,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] irq
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic clr_hit;
        logic set_mask;
        logic clr_mask;

        assign clr_hit  = clr_wr && wbits[i];
        assign set_mask = dis_wr && wbits[i];
        assign clr_mask = en_wr  && wbits[i];

        // Sticky status: a new event wins over a write-one clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (evt[i]) begin
                status[i] <= 1'b1;
            end else if (clr_hit) begin
                status[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[i] <= 1'b1;
            end else if (set_mask) begin
                mask[i] <= 1'b1;
            end else if (clr_mask) begin
                mask[i] <= 1'b0;
            end
        end

        assign irq[i] = status[i] && !mask[i];
    end

endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
    import rtc_ta_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CAL_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_wr,
    input  logic              cal_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] alarm_val,
    output logic [DATA_W-1:0] cal_val,
    output logic [DATA_W-1:0] ctrl_val
);

    localparam logic [DATA_W-1:0] CTRL_KEEP =
        (DATA_W'(1) << CTRL_BATT_BIT) | (DATA_W'(1) << CTRL_OSC_BIT);
    localparam logic [DATA_W-1:0] CAL_KEEP = DATA_W'((64'(1) << CAL_W) - 64'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_val <= '0;
            cal_val   <= '0;
            ctrl_val  <= '0;
        end else begin
            if (alarm_wr) begin
                alarm_val <= wdata;
            end
            if (cal_wr) begin
                cal_val <= wdata & CAL_KEEP;
            end
            if (ctrl_wr) begin
                ctrl_val <= wdata & CTRL_KEEP;
            end
        end
    end

endmodule

// File: rtl/rtc_time_alarm.sv
module rtc_time_alarm
    import rtc_ta_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CAL_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_sec,
    output logic              irq_alarm
);

    localparam int unsigned NS = NUM_SRC;

    logic              wr_tset;
    logic              wr_alarm;
    logic              wr_cal;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              wr_unmask;
    logic              wr_domask;

    logic [DATA_W-1:0] cur_time;
    logic [DATA_W-1:0] set_hold;
    logic              load_pending;
    logic [DATA_W-1:0] alarm_val;
    logic [DATA_W-1:0] cal_val;
    logic [DATA_W-1:0] ctrl_val;
    logic              alarm_hit;
    logic [NS-1:0]     evt;
    logic [NS-1:0]     irq_status;
    logic [NS-1:0]     irq_mask;
    logic [NS-1:0]     irq_vec;

    // Write decode
    assign wr_tset   = bus_wr && (bus_addr == ADDR_W'(OFS_TSET));
    assign wr_alarm  = bus_wr && (bus_addr == ADDR_W'(OFS_ALARM));
    assign wr_cal    = bus_wr && (bus_addr == ADDR_W'(OFS_CAL_WR));
    assign wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat   = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_unmask = bus_wr && (bus_addr == ADDR_W'(OFS_UNMASK));
    assign wr_domask = bus_wr && (bus_addr == ADDR_W'(OFS_DOMASK));

    rtc_time_keeper #(
        .DATA_W (DATA_W)
    ) u_keeper (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_tick     (sec_tick),
        .set_wr       (wr_tset),
        .set_data     (bus_wdata),
        .cur_time     (cur_time),
        .set_hold     (set_hold),
        .load_pending (load_pending)
    );

    rtc_cfg_regs #(
        .DATA_W (DATA_W),
        .CAL_W  (CAL_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_wr  (wr_alarm),
        .cal_wr    (wr_cal),
        .ctrl_wr   (wr_ctrl),
        .wdata     (bus_wdata),
        .alarm_val (alarm_val),
        .cal_val   (cal_val),
        .ctrl_val  (ctrl_val)
    );

    assign alarm_hit    = (cur_time == alarm_val);
    assign evt[SRC_SEC] = sec_tick;
    assign evt[SRC_ALM] = alarm_hit;

    rtc_irq_ctrl #(
        .NSRC (NS)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr_wr (wr_stat),
        .en_wr  (wr_unmask),
        .dis_wr (wr_domask),
        .wbits  (bus_wdata[NS-1:0]),
        .status (irq_status),
        .mask   (irq_mask),
        .irq    (irq_vec)
    );

    assign irq_sec   = irq_vec[SRC_SEC];
    assign irq_alarm = irq_vec[SRC_ALM];

    // Read mux; write-only and unused offsets read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_TSET_RB): bus_rdata = set_hold;
            ADDR_W'(OFS_CAL_RD):  bus_rdata = cal_val;
            ADDR_W'(OFS_NOW):     bus_rdata = cur_time;
            ADDR_W'(OFS_ALARM):   bus_rdata = alarm_val;
            ADDR_W'(OFS_STAT):    bus_rdata = DATA_W'(irq_status);
            ADDR_W'(OFS_MASK):    bus_rdata = DATA_W'(irq_mask);
            ADDR_W'(OFS_CTRL):    bus_rdata = ctrl_val;
            default:              bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_ta_checker.sv
module rtc_ta_checker
    import rtc_ta_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] cur_time,
    input logic [DATA_W-1:0] set_hold,
    input logic              load_pending,
    input logic [DATA_W-1:0] alarm_val,
    input logic [1:0]        status,
    input logic [1:0]        mask,
    input logic              irq_sec,
    input logic              irq_alarm
);

    assert_pending_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && load_pending) |=> (cur_time == $past(set_hold)));

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load_pending) |=> (cur_time == DATA_W'($past(cur_time) + DATA_W'(1))));

    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(cur_time));

    assert_coincident_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && bus_wr && bus_addr == ADDR_W'(OFS_TSET)) |=> load_pending);

    assert_sec_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> status[0]);

    assert_alarm_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_time == alarm_val) |=> status[1]);

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[0] && !sec_tick) |=> !status[0]);

    assert_unmask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_UNMASK) && bus_wdata[1]) |=> !mask[1]);

    assert_domask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_DOMASK) && bus_wdata[0]) |=> mask[0]);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[0] || !status[0]) |-> !irq_sec);

    assert_alarm_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !mask[1]) |-> irq_alarm);

endmodule

bind rtc_time_alarm rtc_ta_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_ta_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .cur_time     (cur_time),
    .set_hold     (set_hold),
    .load_pending (load_pending),
    .alarm_val    (alarm_val),
    .status       (irq_status),
    .mask         (irq_mask),
    .irq_sec      (irq_sec),
    .irq_alarm    (irq_alarm)
);

// File: tb/tb_rtc_time_alarm.sv
`timescale 1ns/1ps
module tb_rtc_time_alarm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_sec;
    logic        irq_alarm;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    rtc_time_alarm dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_sec   (irq_sec),
        .irq_alarm (irq_alarm)
    );

    // Behavioural reference model
    logic [31:0] m_time, m_set, m_alarm, m_cal, m_ctrl;
    logic        m_pend;
    logic [1:0]  m_stat, m_mask;
    logic        m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = 0; m_set = 0; m_alarm = 0; m_cal = 0; m_ctrl = 0;
            m_pend = 0; m_stat = 0; m_mask = 2'b11;
        end else begin
            m_hit = (m_time == m_alarm);
            if (bus_wr && bus_addr == 8'h20) m_stat = m_stat & ~bus_wdata[1:0];
            if (sec_tick) m_stat[0] = 1'b1;
            if (m_hit) m_stat[1] = 1'b1;
            if (sec_tick) begin
                if (m_pend) begin
                    m_time = m_set;
                    m_pend = 0;
                end else begin
                    m_time = m_time + 1;
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: begin m_set = bus_wdata; m_pend = 1; end
                    8'h08: m_cal = bus_wdata & 32'h001F_FFFF;
                    8'h18: m_alarm = bus_wdata;
                    8'h28: m_mask = m_mask & ~bus_wdata[1:0];
                    8'h2C: m_mask = m_mask | bus_wdata[1:0];
                    8'h40: m_ctrl = bus_wdata & 32'h8100_0000;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h04: return m_set;
            8'h0C: return m_cal;
            8'h10: return m_time;
            8'h18: return m_alarm;
            8'h20: return {30'h0, m_stat};
            8'h24: return {30'h0, m_mask};
            8'h40: return m_ctrl;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h04: return "R2";
            8'h0C: return "R11";
            8'h10: return "R3";
            8'h18: return "R6";
            8'h20: return "R7";
            8'h24: return "R8";
            8'h40: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_of(bus_addr), bus_rdata, model_read(bus_addr));
            chk("R9 irq_sec", {31'h0, irq_sec}, {31'h0, m_stat[0] & ~m_mask[0]});
            chk("R9 irq_alarm", {31'h0, irq_alarm}, {31'h0, m_stat[1] & ~m_mask[1]});
        end
    end

    task automatic drive(input logic [7:0] a, input logic w, input logic [31:0] d, input logic t);
        @(negedge clk);
        #1;
        bus_addr = a; bus_wr = w; bus_wdata = d; sec_tick = t;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(a, 1'b1, d, 1'b0);
    endtask

    task automatic tick();
        drive(8'h00, 1'b0, 32'h0, 1'b1);
    endtask

    task automatic idle();
        drive(8'h00, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        #1;
        bus_addr = a; bus_wr = 1'b0; bus_wdata = 32'h0; sec_tick = 1'b0;
        #1;
        v = bus_rdata;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
            summary();
        end
    end

    logic [7:0] offs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                             8'h18, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h40};

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, v); chk("R1 time", v, 32'h0);
        chk("R1 irq pins", {30'h0, irq_alarm, irq_sec}, 32'h0);
        rd(8'h24, v); chk("R1 mask", v, 32'h3);
        rd(8'h40, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h04, v); chk("R1 set readback", v, 32'h0);

        // R2 deferred set
        wr(8'h00, 32'h0000_1000);
        rd(8'h10, v); chk("R2 not yet loaded", v, 32'h0);
        rd(8'h04, v); chk("R2 readback", v, 32'h0000_1000);
        tick();
        rd(8'h10, v); chk("R2 loaded on strobe", v, 32'h0000_1000);
        rd(8'h20, v); chk("R5 and R6 status after strobe", v, 32'h3);
        wr(8'h20, 32'h3);
        rd(8'h20, v); chk("R7 clear both", v, 32'h0);

        // R3 increments and wrap
        tick();
        rd(8'h10, v); chk("R3 increment", v, 32'h0000_1001);
        tick(); tick(); tick();
        rd(8'h10, v); chk("R3 three more", v, 32'h0000_1004);
        wr(8'h00, 32'hFFFF_FFFF);
        tick();
        rd(8'h10, v); chk("R3 at max", v, 32'hFFFF_FFFF);
        tick();
        rd(8'h10, v); chk("R3 wrap", v, 32'h0);

        // R4 set write together with strobe
        drive(8'h00, 1'b1, 32'h50, 1'b1);
        rd(8'h10, v); chk("R4 no load on same strobe", v, 32'h1);
        rd(8'h04, v); chk("R4 held value", v, 32'h50);
        tick();
        rd(8'h10, v); chk("R4 load on next strobe", v, 32'h50);
        wr(8'h00, 32'h60);
        drive(8'h00, 1'b1, 32'h70, 1'b1);
        rd(8'h10, v); chk("R4 older value applied", v, 32'h60);
        rd(8'h04, v); chk("R4 newer value held", v, 32'h70);
        tick();
        rd(8'h10, v); chk("R4 newer value loaded", v, 32'h70);

        // R6 alarm match and re-set after clear
        wr(8'h18, 32'h72);
        wr(8'h20, 32'h3);
        rd(8'h20, v); chk("R7 cleared", v, 32'h0);
        tick(); tick();
        rd(8'h20, v); chk("R5 sec only before match registers", v, 32'h1);
        idle();
        rd(8'h20, v); chk("R6 alarm set", v, 32'h3);
        wr(8'h20, 32'h2);
        rd(8'h20, v); chk("R6 re-set while equal", v, 32'h3);
        wr(8'h20, 32'h1);
        rd(8'h20, v); chk("R7 clear bit0 only", v, 32'h2);
        wr(8'h20, 32'h0);
        rd(8'h20, v); chk("R7 zero write keeps", v, 32'h2);

        // R8 / R9 masking
        chk("R9 masked pins low", {30'h0, irq_alarm, irq_sec}, 32'h0);
        wr(8'h28, 32'h2);
        rd(8'h24, v); chk("R8 unmask alarm", v, 32'h1);
        chk("R9 alarm pin", {31'h0, irq_alarm}, 32'h1);
        wr(8'h2C, 32'h2);
        rd(8'h24, v); chk("R8 mask alarm", v, 32'h3);
        chk("R9 alarm pin masked", {31'h0, irq_alarm}, 32'h0);
        wr(8'h28, 32'h1);
        wr(8'h28, 32'h0);
        rd(8'h24, v); chk("R8 zero write no effect", v, 32'h2);
        chk("R9 sec pin low with clear status", {31'h0, irq_sec}, 32'h0);
        tick();
        rd(8'h24, v);
        chk("R9 sec pin after strobe", {31'h0, irq_sec}, 32'h1);

        // R10 control
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R10 keeps two bits", v, 32'h8100_0000);
        wr(8'h40, 32'h0100_0000);
        rd(8'h40, v); chk("R10 osc only", v, 32'h0100_0000);

        // R11 calibration and read-only words
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R11 calibration", v, 32'h001F_FFFF);
        rd(8'h10, v); chk("R11 time before write", v, 32'h73);
        wr(8'h10, 32'h1234_5678);
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h0C, 32'h0);
        rd(8'h10, v); chk("R11 time unchanged", v, 32'h73);
        rd(8'h04, v); chk("R11 readback unchanged", v, 32'h70);
        rd(8'h0C, v); chk("R11 cal unchanged", v, 32'h001F_FFFF);

        // R12 zero reads
        rd(8'h14, v); chk("R12 tick word", v, 32'h0);
        rd(8'h00, v); chk("R12 set word", v, 32'h0);
        rd(8'h2C, v); chk("R12 disable word", v, 32'h0);
        rd(8'h30, v); chk("R12 unused", v, 32'h0);

        // Mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = offs[$urandom_range(0, 11)];
            d = $urandom;
            if (a == 8'h20 || a == 8'h28 || a == 8'h2C) d = {30'h0, d[1:0]};
            if (a == 8'h18 || a == 8'h00) d = m_time + 32'($urandom_range(0, 3));
            drive(a, ($urandom_range(0, 1) == 1), d, ($urandom_range(0, 3) == 0));
        end
        idle();
        @(negedge clk);
        #2;
        done = 1'b1;
        summary();
    end

endmodule